// File: doc/BRIEF.md
# Quad-Nibble Serial Write Receiver

This block is the receive side of a serial byte-memory slave. It watches a serial clock, an active-low select and four data pins, and turns a quad-address write command into a stream of byte writes to a 512K x 8 storage array. The array itself is outside the block. It sees only a one-cycle write strobe with a 19-bit address and an 8-bit data byte.

The block runs on a system clock. The serial clock, select and data pins arrive already synchronous to that clock, and the block samples the data pins on each rising edge of the serial clock that it detects while select is low.

The opcode phase has two delivery formats. In single-pin format the opcode arrives one bit per edge on pin 0. In nibble format it arrives four bits per edge. Two configuration opcodes switch between the formats, and the chosen format is kept across select cycles. After a write opcode, a 24-bit address and then any number of data bytes follow on all four pins. The address advances after every byte and wraps from the top location back to zero.

Top module: `qwr_rx`

## Requirements
- R1: After reset, and with no command in progress, `wr_en` is low and no write is issued.
- R2: In single-pin format, the write opcode 0x12 is taken on pin 0, most significant bit first, over 8 rising edges of `sck`. Pins 3..1 are ignored during this phase.
- R3: After the write opcode, six rising edges deliver the 24-bit address, most significant nibble first. Within each nibble `sio[3]` is the highest bit. Address bits 23..19 are ignored, and bits 18..0 give the first write location.
- R4: Each data byte takes two rising edges, upper nibble first, with `sio[3]` as the top bit of each nibble. The completed byte raises `wr_en` for exactly one `clk` cycle, with `wr_addr` and `wr_data` valid in that cycle.
- R5: While `cs_n` stays low, each further byte is written to the previous address plus one. After 0x7FFFF the next address is 0x00000.
- R6: Raising `cs_n` ends the command at any point. A byte of which only the upper nibble has arrived is discarded and not written.
- R7: An opcode that is not recognised causes every following edge to be ignored until `cs_n` rises. No write is issued.
- R8: Opcode 0x38 selects nibble format. In nibble format each opcode takes two rising edges, upper nibble first, with `sio[3]` as the top bit. A write sent in single-pin form while nibble format is active is not recognised.
- R9: Opcode 0xFF, in whichever format is active, returns to single-pin format. The selected format persists across `cs_n` cycles and is cleared only by reset.
- R10: Edges of `sck` that occur while `cs_n` is high have no effect and produce no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, synchronous to `clk` |
| cs_n | input | 1 | Active-low select |
| sio | input | 4 | Data pins; pin 3 is the most significant bit of a nibble |
| wr_en | output | 1 | One-cycle write strobe to the array |
| wr_addr | output | 19 | Array byte address |
| wr_data | output | 8 | Byte to write |

## Verification
The assertions assume that `sck`, `cs_n` and `sio` change only between `clk` edges, that each level of `sck` lasts at least one `clk` cycle, and that `sio` is stable when a rising `sck` is sampled. The bench meets these assumptions by changing every input on the falling edge of `clk`. It sets the data pins while `sck` is low and holds each `sck` level for two `clk` cycles. It also keeps `cs_n` steady for several cycles around every select change, so no strobe is in flight when select moves.

// File: rtl/qwr_pkg.sv
// Package: shared types for the quad-nibble write receiver.
// Assumes nothing beyond being compiled before the modules that import it.
package qwr_pkg;
    // Phases of one select cycle.
    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,   // collecting opcode
        PH_ADDR = 2'd1,   // collecting 24-bit address
        PH_DATA = 2'd2,   // collecting data nibbles
        PH_SKIP = 2'd3    // ignoring edges until select rises
    } qwr_phase_t;
endpackage

// File: rtl/qwr_edge_det.sv
// Module: qwr_edge_det
// Detects a rising serial clock while select is low, and reports select-idle.
// Assumes sck and cs_n are already synchronous to clk and that each sck level
// lasts at least one clk cycle.
module qwr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic rise,
    output logic idle
);
    logic sck_q;

    // Keep the previous sck level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    // Report a qualified edge only while select is low.
    always_comb begin
        rise = sck && !sck_q && !cs_n;
        idle = cs_n;
    end
endmodule

// File: rtl/qwr_cmd_fsm.sv
// Module: qwr_cmd_fsm
// Sequences opcode, address and data phases; holds the opcode format mode.
// Assumes rise is a single-cycle pulse per sampled edge and idle is high
// whenever select is deasserted.
module qwr_cmd_fsm
    import qwr_pkg::*;
#(
    parameter int          AW      = 19,
    parameter int          CMD_AW  = 24,
    parameter int          OPW     = 8,
    parameter logic [7:0]  OP_WR   = 8'h12,
    parameter logic [7:0]  OP_QON  = 8'h38,
    parameter logic [7:0]  OP_QOFF = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          idle,
    input  logic [3:0]    sio,
    output logic          addr_load,
    output logic [AW-1:0] addr_val,
    output logic          byte_done,
    output logic [7:0]    byte_val
);
    localparam int ANIB   = CMD_AW / 4;
    localparam int CW     = $clog2(OPW > ANIB ? OPW : ANIB);
    localparam logic [CW-1:0] STD_LAST  = CW'(OPW - 1);
    localparam logic [CW-1:0] QUAD_LAST = CW'(OPW / 4 - 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(ANIB - 1);

    qwr_phase_t         phase;
    logic [CW-1:0]      cnt;
    logic               quad;
    logic               half;
    logic [3:0]         hi_nib;
    logic [OPW-1:0]     opc_sr;
    logic [CMD_AW-5:0]  addr_sr;
    logic [OPW-1:0]     opc_full;
    logic [CMD_AW-1:0]  addr_full;
    logic               opc_last;

    // Form the opcode and address including the nibble or bit arriving now.
    always_comb begin
        opc_full  = quad ? {opc_sr[OPW-5:0], sio} : {opc_sr[OPW-2:0], sio[0]};
        addr_full = {addr_sr, sio};
        opc_last  = (cnt == (quad ? QUAD_LAST : STD_LAST));
    end

    // Announce address capture and completed bytes to the address counter.
    always_comb begin
        addr_load = rise && (phase == PH_ADDR) && (cnt == ADDR_LAST);
        addr_val  = addr_full[AW-1:0];
        byte_done = rise && (phase == PH_DATA) && half;
        byte_val  = {hi_nib, sio};
    end

    // Phase sequencing, shift registers and the persistent format mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_OPC;
            cnt     <= '0;
            quad    <= 1'b0;
            half    <= 1'b0;
            hi_nib  <= '0;
            opc_sr  <= '0;
            addr_sr <= '0;
        end else if (idle) begin
            phase <= PH_OPC;
            cnt   <= '0;
            half  <= 1'b0;
        end else if (rise) begin
            case (phase)
                PH_OPC: begin
                    opc_sr <= opc_full;
                    cnt    <= cnt + 1'b1;
                    if (opc_last) begin
                        cnt <= '0;
                        if (opc_full == OP_WR) begin
                            phase <= PH_ADDR;
                        end else begin
                            phase <= PH_SKIP;
                            if (opc_full == OP_QON)  quad <= 1'b1;
                            if (opc_full == OP_QOFF) quad <= 1'b0;
                        end
                    end
                end
                PH_ADDR: begin
                    addr_sr <= addr_full[CMD_AW-5:0];
                    cnt     <= cnt + 1'b1;
                    if (cnt == ADDR_LAST) begin
                        cnt   <= '0;
                        phase <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    half <= !half;
                    if (!half) hi_nib <= sio;
                end
                default: phase <= PH_SKIP;
            endcase
        end
    end
endmodule

// File: rtl/qwr_addr_ctr.sv
// Module: qwr_addr_ctr
// Holds the running array address and registers the write strobe.
// Assumes addr_load and byte_done never pulse in the same cycle.
module qwr_addr_ctr #(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_val,
    input  logic          byte_done,
    input  logic [7:0]    byte_val,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    logic [AW-1:0] cur;

    // Load the start address, then issue one strobe per byte and advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (addr_load) begin
                cur <= addr_val;
            end else if (byte_done) begin
                wr_en   <= 1'b1;
                wr_addr <= cur;
                wr_data <= byte_val;
                cur     <= cur + 1'b1;
            end
        end
    end
endmodule

// File: rtl/qwr_rx.sv
// Module: qwr_rx (top)
// Receives quad-address write commands and drives a byte write strobe.
// Assumes sck, cs_n and sio are synchronous to clk.
module qwr_rx #(
    parameter int         AW      = 19,
    parameter int         CMD_AW  = 24,
    parameter int         OPW     = 8,
    parameter logic [7:0] OP_WR   = 8'h12,
    parameter logic [7:0] OP_QON  = 8'h38,
    parameter logic [7:0] OP_QOFF = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic [3:0]    sio,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    logic          rise;
    logic          idle;
    logic          addr_load;
    logic [AW-1:0] addr_val;
    logic          byte_done;
    logic [7:0]    byte_val;

    qwr_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .cs_n  (cs_n),
        .rise  (rise),
        .idle  (idle)
    );

    qwr_cmd_fsm #(
        .AW      (AW),
        .CMD_AW  (CMD_AW),
        .OPW     (OPW),
        .OP_WR   (OP_WR),
        .OP_QON  (OP_QON),
        .OP_QOFF (OP_QOFF)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .idle      (idle),
        .sio       (sio),
        .addr_load (addr_load),
        .addr_val  (addr_val),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    qwr_addr_ctr #(
        .AW (AW)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .addr_val  (addr_val),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/qwr_rx_chk.sv
// Module: qwr_rx_chk
// Port-level properties of the write receiver, bound to qwr_rx.
// Assumes inputs are synchronous to clk.
module qwr_rx_chk #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sck,
    input logic          cs_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr
);
    logic          have_last;
    logic [AW-1:0] last_addr;
    logic [AW-1:0] next_addr;

    // Track the previous strobe address within one select cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            have_last <= 1'b0;
            last_addr <= '0;
        end else if (wr_en) begin
            have_last <= 1'b1;
            last_addr <= wr_addr;
        end
    end

    // Expected successor address, wrapping at the top.
    always_comb next_addr = last_addr + 1'b1;

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4
    strobe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(sck) && !$past(sck, 2)));

    // R10
    strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(cs_n));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_last && !cs_n) |-> (wr_addr == next_addr));
endmodule

bind qwr_rx qwr_rx_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (sck),
    .cs_n    (cs_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/test_qwr_rx.sv
// Bench: sweeps write bursts over addresses, lengths and both opcode formats,
// with expected addresses and data computed arithmetically.
module test_qwr_rx;
    localparam int         AW      = 19;
    localparam logic [7:0] OP_WR   = 8'h12;
    localparam logic [7:0] OP_QON  = 8'h38;
    localparam logic [7:0] OP_QOFF = 8'hFF;
    localparam int         LOGN    = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic [3:0]    sio = 4'h0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    int            cap_n = 0;
    logic [AW-1:0] cap_a [LOGN];
    logic [7:0]    cap_d [LOGN];

    always #10 clk = ~clk;

    qwr_rx i_qwr_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .sio     (sio),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // Log every strobe away from the active edge.
    always @(negedge clk) begin
        if (wr_en && cap_n < LOGN) begin
            cap_a[cap_n] = wr_addr;
            cap_d[cap_n] = wr_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [3:0] v);
        sio = v;
        wait_clk(2);
        sck = 1'b1;
        wait_clk(2);
        sck = 1'b0;
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(2);
    endtask

    task automatic desel();
        wait_clk(3);
        cs_n = 1'b1;
        wait_clk(3);
    endtask

    task automatic send_op(input logic [7:0] op, input bit q);
        if (q) begin
            pulse(op[7:4]);
            pulse(op[3:0]);
        end else begin
            for (int i = 7; i >= 0; i--) pulse({3'b101, op[i]});
        end
    endtask

    task automatic send_addr(input logic [23:0] a);
        for (int n = 5; n >= 0; n--) pulse(a[n*4 +: 4]);
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 13 + i * 29 + 7);
    endfunction

    // Send one write burst and compare the logged strobes with arithmetic.
    task automatic burst(input bit q, input logic [23:0] a, input int n,
                         input int seed, input bit extra_half, input string req);
        int base;
        logic [AW-1:0] ea;
        base = cap_n;
        sel();
        send_op(OP_WR, q);
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            pulse(pat(seed, i) >> 4);
            pulse(pat(seed, i) & 8'h0F);
        end
        if (extra_half) pulse(4'hA);
        desel();
        check(cap_n - base == n, req, "strobe count", cap_n - base, n);
        for (int i = 0; i < n && base + i < LOGN; i++) begin
            ea = a[AW-1:0] + AW'(i);
            check(cap_a[base+i] == ea, req, "address", int'(cap_a[base+i]), int'(ea));
            check(cap_d[base+i] == pat(seed, i), req, "data",
                  int'(cap_d[base+i]), int'(pat(seed, i)));
        end
    endtask

    task automatic config_op(input logic [7:0] op, input bit q);
        sel();
        send_op(op, q);
        desel();
    endtask

    initial begin
        int base;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: idle after reset
        check(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
        check(cap_n == 0, "R1", "writes after reset", cap_n, 0);

        // R2 R3 R4: sweep start addresses and lengths in single-pin format
        for (int s = 0; s < 8; s++) begin
            burst(1'b0, {5'(s * 7), 19'(s * 20011)}, 1 + s % 4, s, 1'b0, "R3");
        end
        burst(1'b0, 24'h000000, 3, 40, 1'b0, "R2");
        burst(1'b0, 24'hF8ABCD, 2, 41, 1'b0, "R4");

        // R5: long burst across the top address
        burst(1'b0, 24'h07FFF9, 12, 50, 1'b0, "R5");
        burst(1'b0, 24'hFFFFFF, 3, 51, 1'b0, "R5");

        // R6: trailing half byte is dropped
        burst(1'b0, 24'h012345, 2, 60, 1'b1, "R6");
        burst(1'b0, 24'h000100, 0, 61, 1'b1, "R6");

        // R7: unknown opcode ignores a whole write-shaped sequence
        base = cap_n;
        sel();
        send_op(8'hA5, 1'b0);
        send_addr(24'h000010);
        for (int i = 0; i < 4; i++) begin pulse(4'h1); pulse(4'h2); end
        desel();
        check(cap_n == base, "R7", "writes after unknown opcode", cap_n - base, 0);
        burst(1'b0, 24'h000020, 2, 70, 1'b0, "R7");

        // R10: edges while deselected do nothing
        base = cap_n;
        send_op(OP_WR, 1'b0);
        send_addr(24'h000200);
        for (int i = 0; i < 3; i++) begin pulse(4'h5); pulse(4'h6); end
        wait_clk(4);
        check(cap_n == base, "R10", "writes while deselected", cap_n - base, 0);
        burst(1'b0, 24'h000300, 1, 80, 1'b0, "R10");

        // R8: switch to nibble format, persists over several select cycles
        config_op(OP_QON, 1'b0);
        burst(1'b1, 24'h07FFFE, 4, 90, 1'b0, "R8");
        burst(1'b1, 24'h100040, 3, 91, 1'b0, "R9");
        base = cap_n;
        sel();
        send_op(OP_WR, 1'b0);
        send_addr(24'h000050);
        pulse(4'h3); pulse(4'h4);
        desel();
        check(cap_n == base, "R8", "single-pin opcode in nibble format", cap_n - base, 0);

        // R9: leave nibble format using a nibble-format opcode
        config_op(OP_QOFF, 1'b1);
        burst(1'b0, 24'h055555, 2, 100, 1'b0, "R9");

        // R1: idle again at the end
        wait_clk(4);
        check(wr_en == 1'b0, "R1", "wr_en idle at end", int'(wr_en), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule